// File: doc/BRIEF.md
# RTC Power-Control and Event-Flag Register

This block is one 8-bit control and status location inside a real-time-clock register file. Software reaches it over a simple synchronous bus. The location is decoded by a bank select plus an address, and reads are combinational. The register holds three event flags: RAM-clear, wake-up alarm and kickstart. Hardware sets these flags and software clears them. Software may also force a flag to 1 to raise an interrupt condition on purpose. The register also holds a burst-mode enable, a spare read/write bit and a power-output control bit. Two read-only status levels are mirrored into it: battery present and update pending.

The power-control bit drives an open-drain style power output. When the bit is 0 the output pulls low. When the bit is 1 the output is released to high impedance. Hardware clears the bit whenever the wake-up flag meets its interrupt enable, or the kickstart flag meets its enable, so the system powers back up. The RAM-clear flag comes from an asynchronous pin. The pin is synchronised, and only a falling edge that arrives while the clear-enable input is high sets the flag. Timekeeping, the alarm comparators and the RAM itself are outside this block. They appear only as input levels and pulses.

Top module: `rtc_pwrctl_reg`

## Requirements
- R1: A read with `bus_bank`=1 and `bus_addr`=0x4A returns bits [7:0] = {battery-valid, update-pending, burst-enable, spare, power-control, RAM-clear flag, wake flag, kick flag}. Any other bank or address reads 0x00.
- R2: A write changes the register only when `bus_bank`=1 and `bus_addr`=0x4A. A write to any other location leaves every bit unchanged.
- R3: With `clr_en`=1, a high-to-low transition on `clr_pin_n` sets the RAM-clear flag (bit 2). The flag reads 1 no later than the third rising clock edge after the fall.
- R4: A fall of `clr_pin_n` while `clr_en`=0 does not set bit 2. A rise of the pin never sets it.
- R5: A one-cycle `wake_evt` pulse sets bit 1, and a one-cycle `kick_evt` pulse sets bit 0. The new value is readable after that clock edge.
- R6: An addressed write of 0 to bit 2, 1 or 0 clears that flag. A write of 1 sets it.
- R7: If a hardware set and a software write of 0 hit the same flag on the same edge, the flag ends at 1.
- R8: While (bit 1 and `wake_ie`) or (bit 0 and `kick_ie`) is true at a clock edge, bit 3 is 0 after that edge, even if the same write sets bit 3 to 1.
- R9: `pwr_pull_low` is 1 exactly when bit 3 is 0. `burst_en` equals bit 5.
- R10: Bit 7 mirrors `batt_ok` and bit 6 mirrors `upd_pending`. Writes to these two bits have no effect.
- R11: Bit 4 reads back what was last written to it and affects no output or other bit.
- R12: After reset every writable bit is 0, so `pwr_pull_low`=1 and `burst_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_bank | input | 1 | Register bank select |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| batt_ok | input | 1 | Battery-present level |
| upd_pending | input | 1 | Update-pending level from the timekeeper |
| clr_pin_n | input | 1 | Asynchronous RAM-clear pin, active low |
| clr_en | input | 1 | Enables RAM-clear edge detection |
| wake_evt | input | 1 | Wake-up alarm event pulse |
| kick_evt | input | 1 | Kickstart event pulse |
| wake_ie | input | 1 | Wake-up interrupt enable |
| kick_ie | input | 1 | Kickstart enable |
| pwr_pull_low | output | 1 | 1 = power output pulled low, 0 = released |
| burst_en | output | 1 | Burst auto-increment enable for the RAM address logic |

## Verification
A vector table drives plain writes, lone wake and kick pulses, and enable changes. It also lines up events against writes on the same edge. This shows whether hardware sets win over software clears, and whether the forced power clear beats a software write of 1. It also shows that the forced clear follows the stored flag and not the pulse. Directed tests cover the RAM-clear pin three ways: a fall with the enable set, a fall with the enable clear, and a rise alone. This exposes a missing enable gate or a detector that fires on the wrong polarity. Writes to wrong banks and addresses, and writes to the read-only bits, confirm that decoding and mirroring do not leak.

// File: rtl/rtc_pwrctl_pkg.sv
// Package: bit positions of the power-control status register.
// Assumes an 8-bit data path; positions are fixed because software decodes them.
package rtc_pwrctl_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 3;
    localparam int B_KICK    = 0;
    localparam int B_WAKE    = 1;
    localparam int B_RCLR    = 2;
    localparam int B_PWR     = 3;
    localparam int B_SPARE   = 4;
    localparam int B_BURST   = 5;
    localparam int B_UPD     = 6;
    localparam int B_BATT    = 7;
endpackage

// File: rtl/rtc_pin_fall_det.sv
// Module: synchronises an asynchronous active-low pin and flags its falling edge.
// Assumes the pin idles high; the chain resets to 1 so reset makes no edge.
module rtc_pin_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fell
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last;

    // Shift the pin through the synchroniser and keep the previous synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin_n};
            last  <= chain[SYNC_STAGES-1];
        end
    end

    // Falling edge of the synchronised level.
    always_comb fell = last & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/rtc_evt_flag.sv
// Module: one event flag, set by hardware and written by software.
// Assumes the hardware set wins over a same-cycle software write.
module rtc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic q
);
    // Update the flag: hardware set first, then software write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (hw_set) q <= 1'b1;
        else if (sw_wr)  q <= sw_val;
    end
endmodule

// File: rtl/rtc_pwrctl_reg.sv
// Module: power-control and event-flag register of the RTC register file.
// Assumes a single-cycle write strobe and combinational read data; the
// event inputs are synchronous one-cycle pulses, enables are levels.
module rtc_pwrctl_reg
    import rtc_pwrctl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic        REG_BANK = 1'b1,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_bank,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              batt_ok,
    input  logic              upd_pending,
    input  logic              clr_pin_n,
    input  logic              clr_en,
    input  logic              wake_evt,
    input  logic              kick_evt,
    input  logic              wake_ie,
    input  logic              kick_ie,
    output logic              pwr_pull_low,
    output logic              burst_en
);
    logic                 reg_hit;
    logic                 reg_wr;
    logic                 clr_fell;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 pwr_q;
    logic                 spare_q;
    logic                 burst_q;
    logic                 pwr_force;

    // Address decode for this location.
    always_comb reg_hit = (bus_bank == REG_BANK) && (bus_addr == REG_ADDR);
    always_comb reg_wr  = bus_wr && reg_hit;

    rtc_pin_fall_det #(.SYNC_STAGES(2)) u_clr_det (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (clr_pin_n),
        .fell  (clr_fell)
    );

    // Hardware set sources, indexed by flag bit position.
    always_comb begin
        flag_set         = '0;
        flag_set[B_KICK] = kick_evt;
        flag_set[B_WAKE] = wake_evt;
        flag_set[B_RCLR] = clr_fell & clr_en;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        rtc_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (flag_set[i]),
            .sw_wr  (reg_wr),
            .sw_val (bus_wdata[i]),
            .q      (flag_q[i])
        );
    end

    // Enabled stored wake or kick flag forces the power output active.
    always_comb pwr_force = (flag_q[B_WAKE] & wake_ie) | (flag_q[B_KICK] & kick_ie);

    // Power-control bit: forced clear beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pwr_q <= 1'b0;
        else if (pwr_force) pwr_q <= 1'b0;
        else if (reg_wr)    pwr_q <= bus_wdata[B_PWR];
    end

    // Plain software-owned bits: spare and burst enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= 1'b0;
            burst_q <= 1'b0;
        end else if (reg_wr) begin
            spare_q <= bus_wdata[B_SPARE];
            burst_q <= bus_wdata[B_BURST];
        end
    end

    // Read mux: assembled register when addressed, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (reg_hit) begin
            bus_rdata[B_BATT]              = batt_ok;
            bus_rdata[B_UPD]               = upd_pending;
            bus_rdata[B_BURST]             = burst_q;
            bus_rdata[B_SPARE]             = spare_q;
            bus_rdata[B_PWR]               = pwr_q;
            bus_rdata[NUM_FLAGS-1:0]       = flag_q;
        end
    end

    // Pin-facing outputs.
    always_comb pwr_pull_low = ~pwr_q;
    always_comb burst_en     = burst_q;
endmodule

// File: rtl/rtc_pwrctl_chk.sv
// Module: property checker bound to rtc_pwrctl_reg.
// Assumes it observes the top's ports and its stored flags through the bind.
module rtc_pwrctl_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic              REG_BANK = 1'b1,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_bank,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              clr_en,
    input logic              wake_evt,
    input logic              kick_evt,
    input logic              wake_ie,
    input logic              kick_ie,
    input logic              pwr_pull_low,
    input logic              burst_en,
    input logic [2:0]        flag_q
);
    logic hit;
    always_comb hit = (bus_bank == REG_BANK) && (bus_addr == REG_ADDR);

    // R2
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit) |=> $stable(burst_en));

    // R4
    rclr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[2] && !clr_en && !(bus_wr && hit)) |=> !flag_q[2]);

    // R5
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> flag_q[1]);

    // R5
    kick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_evt |=> flag_q[0]);

    // R6
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && !bus_wdata[1] && !wake_evt) |=> !flag_q[1]);

    // R8
    wake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && wake_ie) |=> pwr_pull_low);

    // R8
    kick_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && kick_ie) |=> pwr_pull_low);

    // R9
    pwr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pwr_pull_low != bus_rdata[3]));

    // R1
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == 8'h00));
endmodule

bind rtc_pwrctl_reg rtc_pwrctl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_BANK (REG_BANK),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_bank     (bus_bank),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .clr_en       (clr_en),
    .wake_evt     (wake_evt),
    .kick_evt     (kick_evt),
    .wake_ie      (wake_ie),
    .kick_ie      (kick_ie),
    .pwr_pull_low (pwr_pull_low),
    .burst_en     (burst_en),
    .flag_q       (flag_q)
);

// File: tb/rtc_pwrctl_reg_tb.sv
// Bench: vector table for writes, events and enables, then directed tests.
module rtc_pwrctl_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_bank = 1'b1;
    logic [7:0] bus_addr = 8'h4A;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       batt_ok = 1'b1;
    logic       upd_pending = 1'b0;
    logic       clr_pin_n = 1'b1;
    logic       clr_en = 1'b0;
    logic       wake_evt = 1'b0;
    logic       kick_evt = 1'b0;
    logic       wake_ie = 1'b0;
    logic       kick_ie = 1'b0;
    logic       pwr_pull_low;
    logic       burst_en;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    rtc_pwrctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_bank(bus_bank), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .batt_ok(batt_ok), .upd_pending(upd_pending), .clr_pin_n(clr_pin_n),
        .clr_en(clr_en), .wake_evt(wake_evt), .kick_evt(kick_evt),
        .wake_ie(wake_ie), .kick_ie(kick_ie), .pwr_pull_low(pwr_pull_low),
        .burst_en(burst_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One step: drive at negedge, pass one rising edge, return at next negedge.
    task automatic step(input logic wr, input logic [7:0] wd, input logic we, input logic ke);
        bus_wr = wr; bus_wdata = wd; wake_evt = we; kick_evt = ke;
        @(negedge clk);
        bus_wr = 1'b0; wake_evt = 1'b0; kick_evt = 1'b0;
    endtask

    // {wr, wdata[7:0], wake_evt, kick_evt, wake_ie, kick_ie, exp_read[7:0], exp_pull_low}
    localparam int NV = 11;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'h38, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB8, 1'b0}, // R6 R11 plain write
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hBA, 1'b0}, // R5 wake pulse
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB2, 1'b1}, // R8 enabled wake forces clear
        {1'b1, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1}, // R8 force beats write of 1
        {1'b1, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h88, 1'b0}, // R9 release once flag gone
        {1'b1, 8'h08, 1'b0, 1'b1, 1'b0, 1'b1, 8'h89, 1'b0}, // R7 kick beats clear
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1}, // R8 enabled kick forces clear
        {1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 8'h87, 1'b1}, // R6 software force flags
        {1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h82, 1'b1}, // R7 wake beats clear
        {1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h90, 1'b1}, // R11 spare only
        {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA0, 1'b1}  // R9 burst bit
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 reset read", bus_rdata, 8'h80);
        chk("R12 reset pull_low", {7'b0, pwr_pull_low}, 8'h01);
        chk("R12 reset burst", {7'b0, burst_en}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wake_ie = VEC[i][10];
            kick_ie = VEC[i][9];
            step(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11]);
            chk($sformatf("R5-table vec %0d read", i), bus_rdata, VEC[i][8:1]);
            chk($sformatf("R9 vec %0d pull_low", i), {7'b0, pwr_pull_low}, {7'b0, VEC[i][0]});
        end
        chk("R9 burst output", {7'b0, burst_en}, 8'h01);
        wake_ie = 1'b0; kick_ie = 1'b0;

        // R10 read-only mirrors, writes ignored
        step(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R10 write to ro bits", bus_rdata, 8'h80);
        batt_ok = 1'b0; upd_pending = 1'b1;
        @(negedge clk);
        chk("R10 mirror levels", bus_rdata, 8'h40);
        batt_ok = 1'b1; upd_pending = 1'b0;

        // R2 writes elsewhere ignored
        bus_addr = 8'h4B;
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        chk("R1 other address reads zero", bus_rdata, 8'h00);
        bus_addr = 8'h4A; bus_bank = 1'b0;
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        chk("R1 other bank reads zero", bus_rdata, 8'h00);
        bus_bank = 1'b1;
        @(negedge clk);
        chk("R2 foreign writes ignored", bus_rdata, 8'h80);
        chk("R2 burst untouched", {7'b0, burst_en}, 8'h00);

        // R4 fall with enable low
        clr_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 gated fall", bus_rdata, 8'h80);
        clr_en = 1'b1;
        clr_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 rise does not set", bus_rdata, 8'h80);

        // R3 fall with enable high: set by third edge
        clr_pin_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 rclr set", bus_rdata, 8'h84);
        step(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R6 rclr cleared", bus_rdata, 8'h80);
        clr_pin_n = 1'b1; clr_en = 1'b0;
        repeat (4) @(negedge clk);

        // R12 reset in mid-operation
        step(1'b1, 8'h3F, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 reset clears", bus_rdata, 8'h80);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule